// File: doc/BRIEF.md
# UART-to-PCM Elastic Sample Bridge

This block takes voice samples that arrive as bytes on an asynchronous serial line (8 data bits, no parity, one stop bit, nominally 115200 baud) and plays them onto a synchronous PCM bus. The PCM bus carries one byte per frame, in a single timeslot marked by an enable input. The sender delivers its bytes in bursts, typically eight at a time once per millisecond. The PCM frame rate is 8 kHz, taken from a free-running 2.048 MHz bit clock. Incoming bytes are held in a FIFO between the two sides.

The serial sender and the PCM bit clock are not locked together, so over time the FIFO would drain or fill. The block corrects this at each frame boundary, using the FIFO occupancy against two watermarks. When the occupancy is high, the block discards one byte. When the occupancy is low, it sends the previous byte a second time. This keeps the backlog near the middle of the FIFO, and each slip costs only one sample.

The block runs entirely on one fast system clock. The serial line, the PCM bit clock and the slot enable are synchronised to that clock, and their edges are detected in logic. Companding, frame-sync generation and the sending side are outside the block.

Top module: `uart_pcm_slip_bridge`

## Requirements
- R1: The serial line is received as a start bit, 8 data bits least significant bit first, and a stop bit, using 16 oversampling ticks per bit. One tick lasts OVS_DIV system clocks. Each good byte is appended to the FIFO in arrival order.
- R2: A low pulse on the idle line that ends before the middle of the start bit (tick 8) is rejected. It adds no byte to the FIFO.
- R3: A byte whose stop bit samples low is discarded. The receiver then waits until the line is high before it looks for the next start bit.
- R4: The first rising PCM bit-clock edge that sees the slot enable high loads a new byte. That byte is driven most significant bit first, one bit per rising edge, over 8 edges.
- R5: On any rising bit-clock edge that sees the slot enable low, the data output is driven to 1 (idle 0xFF). After reset the data output is 1 and both flags are 0.
- R6: At a slot load, if the FIFO occupancy N satisfies LOW_MARK <= N <= HIGH_MARK, the oldest byte is popped and sent.
- R7: At a slot load, if N > HIGH_MARK, the oldest byte is discarded and the next one is popped and sent, so the occupancy drops by two.
- R8: At a slot load, if 0 < N < LOW_MARK, the previously sent byte is sent again and nothing is popped.
- R9: At a slot load with an empty FIFO, the previously sent byte is repeated and the sticky underflow flag is set. The previously sent byte is 0xFF after reset.
- R10: A byte received while the FIFO holds DEPTH entries is dropped, the FIFO contents stay unchanged, and the sticky overflow flag is set.
- R11: Once set, each flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxSerial | input | 1 | Asynchronous serial input, idle high |
| pcmBitClk | input | 1 | PCM bit clock, asynchronous |
| slotEnable | input | 1 | High during the 8 bit clocks of the timeslot |
| pcmData | output | 1 | PCM serial data, idle 1 |
| underflowFlag | output | 1 | Sticky: a slot found the FIFO empty |
| overflowFlag | output | 1 | Sticky: a byte arrived while the FIFO was full |

## Verification
A fault in the occupancy count or in the read pointer shows at the data output within one frame. The wrong byte appears, or a repeat or drop decision comes at the wrong time. From that point the whole sequence of sent bytes differs from the queue model. A fault in the receiver shows up as an extra or missing byte in the FIFO. It therefore also appears at the first slot that would have sent that entry, so the bench compares every bit of every slot and the flags after every frame and every byte.

// File: rtl/slip_bridge_pkg.sv
package slip_bridge_pkg;
  // Strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic push;   // write received byte into FIFO
    logic pop;    // slot load: send head, pop one
    logic drop;   // slot load: discard head, send next, pop two
    logic rpt;    // slot load: resend previous byte, no pop
    logic load;   // first bit of slot
    logic shift;  // later bit of slot
    logic idle;   // bit edge outside the slot
  } slip_ctl_t;
endpackage

// File: rtl/pcm_uart_rx.sv
module pcm_uart_rx #(
  parameter int OVS_DIV = 68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  output logic       byteValid,
  output logic [7:0] byteData
);
  localparam int DIV_W = $clog2(OVS_DIV + 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT} rx_state_t;

  rx_state_t  state;
  logic [DIV_W-1:0] divCnt;
  logic       tick;
  logic [3:0] tickCnt;
  logic [2:0] bitCnt;
  logic [7:0] shiftReg;

  assign tick = (divCnt == DIV_W'(OVS_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (!rxLine) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (tickCnt == 4'd7) begin
            tickCnt <= '0;
            state   <= rxLine ? RX_IDLE : RX_DATA;
          end else tickCnt <= tickCnt + 4'd1;
        end
        RX_DATA: if (tick) begin
          if (tickCnt == 4'd15) begin
            tickCnt  <= '0;
            shiftReg <= {rxLine, shiftReg[7:1]};
            if (bitCnt == 3'd7) state <= RX_STOP;
            bitCnt <= bitCnt + 3'd1;
          end else tickCnt <= tickCnt + 4'd1;
        end
        RX_STOP: if (tick) begin
          if (tickCnt == 4'd15) begin
            tickCnt <= '0;
            if (rxLine) begin
              byteValid <= 1'b1;
              byteData  <= shiftReg;
              state     <= RX_IDLE;
            end else state <= RX_WAIT;
          end else tickCnt <= tickCnt + 4'd1;
        end
        RX_WAIT: if (rxLine) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  // R3
  wait_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_WAIT && !rxLine) |=> state == RX_WAIT);
endmodule

// File: rtl/pcm_slip_ctrl.sv
module pcm_slip_ctrl
  import slip_bridge_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HIGH_MARK = 24,
  parameter int LOW_MARK  = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxSerial,
  input  logic             pcmBitClk,
  input  logic             slotEnable,
  input  logic             rxValid,
  input  logic [CNT_W-1:0] fillLevel,
  output logic             rxLine,
  output slip_ctl_t        ctl,
  output logic             underflowFlag,
  output logic             overflowFlag
);
  localparam logic [CNT_W-1:0] FULL_L = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HI_L   = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] LO_L   = CNT_W'(LOW_MARK);

  logic [1:0] rxSync, clkSync, slotSync;
  logic       clkPrev;
  logic       bitRise;
  logic [2:0] bitCnt;
  logic       isEmpty, isFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync   <= 2'b11;
      clkSync  <= 2'b00;
      slotSync <= 2'b00;
      clkPrev  <= 1'b0;
    end else begin
      rxSync   <= {rxSync[0], rxSerial};
      clkSync  <= {clkSync[0], pcmBitClk};
      slotSync <= {slotSync[0], slotEnable};
      clkPrev  <= clkSync[1];
    end
  end

  assign rxLine  = rxSync[1];
  assign bitRise = clkSync[1] && !clkPrev;
  assign isEmpty = (fillLevel == '0);
  assign isFull  = (fillLevel == FULL_L);

  always_ff @(posedge clk) begin
    if (!rstN) bitCnt <= '0;
    else if (bitRise) bitCnt <= slotSync[1] ? bitCnt + 3'd1 : 3'd0;
  end

  always_comb begin
    ctl       = '0;
    ctl.load  = bitRise && slotSync[1] && (bitCnt == 3'd0);
    ctl.shift = bitRise && slotSync[1] && (bitCnt != 3'd0);
    ctl.idle  = bitRise && !slotSync[1];
    ctl.drop  = ctl.load && (fillLevel > HI_L);
    ctl.rpt   = ctl.load && (fillLevel < LO_L);
    ctl.pop   = ctl.load && !ctl.drop && !ctl.rpt;
    ctl.push  = rxValid && !isFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      underflowFlag <= 1'b0;
      overflowFlag  <= 1'b0;
    end else begin
      if (ctl.load && isEmpty) underflowFlag <= 1'b1;
      if (rxValid && isFull)   overflowFlag  <= 1'b1;
    end
  end

  // R11
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);
  // R11
  of_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);
  // R6
  one_choice_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.pop, ctl.drop, ctl.rpt}));
endmodule

// File: rtl/pcm_slip_datapath.sv
module pcm_slip_datapath
  import slip_bridge_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HIGH_MARK = 24,
  parameter int LOW_MARK  = 8,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  slip_ctl_t        ctl,
  input  logic [7:0]       rxByte,
  output logic [CNT_W-1:0] fillLevel,
  output logic             pcmOut
);
  localparam logic [CNT_W-1:0] FULL_L = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HI_L   = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] LO_L   = CNT_W'(LOW_MARK);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, rdNext;
  logic [CNT_W-1:0] popAmt;
  logic [7:0]       lastByte, shiftReg, chosen;

  assign rdNext = rdPtr + PTR_W'(1);
  assign popAmt = ctl.drop ? CNT_W'(2) : (ctl.pop ? CNT_W'(1) : CNT_W'(0));
  assign chosen = ctl.rpt ? lastByte : (ctl.drop ? mem[rdNext] : mem[rdPtr]);

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + PTR_W'(1);
      rdPtr     <= rdPtr + PTR_W'(popAmt);
      fillLevel <= fillLevel + CNT_W'(ctl.push) - popAmt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastByte <= 8'hFF;
      shiftReg <= 8'hFF;
      pcmOut   <= 1'b1;
    end else if (ctl.load) begin
      lastByte <= chosen;
      pcmOut   <= chosen[7];
      shiftReg <= {chosen[6:0], 1'b1};
    end else if (ctl.shift) begin
      pcmOut   <= shiftReg[7];
      shiftReg <= {shiftReg[6:0], 1'b1};
    end else if (ctl.idle) begin
      pcmOut   <= 1'b1;
    end
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FULL_L);
  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> fillLevel != FULL_L);
  // R7
  drop_above_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drop |-> fillLevel > HI_L);
  // R8
  repeat_below_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rpt |-> fillLevel < LO_L);
  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> pcmOut);
endmodule

// File: rtl/uart_pcm_slip_bridge.sv
module uart_pcm_slip_bridge
  import slip_bridge_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HIGH_MARK = 24,
  parameter int LOW_MARK  = 8,
  parameter int OVS_DIV   = 68
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxSerial,
  input  logic pcmBitClk,
  input  logic slotEnable,
  output logic pcmData,
  output logic underflowFlag,
  output logic overflowFlag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  slip_ctl_t        ctl;
  logic             rxLine, rxValid;
  logic [7:0]       rxByte;
  logic [CNT_W-1:0] fillLevel;

  pcm_uart_rx #(.OVS_DIV(OVS_DIV)) u_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine),
    .byteValid(rxValid), .byteData(rxByte)
  );

  pcm_slip_ctrl #(.DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial), .pcmBitClk(pcmBitClk),
    .slotEnable(slotEnable), .rxValid(rxValid), .fillLevel(fillLevel),
    .rxLine(rxLine), .ctl(ctl), .underflowFlag(underflowFlag),
    .overflowFlag(overflowFlag)
  );

  pcm_slip_datapath #(.DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte),
    .fillLevel(fillLevel), .pcmOut(pcmData)
  );
endmodule

// File: tb/tb_uart_pcm_slip_bridge.sv
module tb_uart_pcm_slip_bridge;
  localparam int DEPTH = 32, HIGH = 24, LOW = 8, DIV = 2;
  localparam int BIT_LEN = 16 * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0, rxSerial = 1'b1, pcmBitClk = 1'b0, slotEnable = 1'b0;
  logic pcmData, underflowFlag, overflowFlag;

  int nChk = 0, nFail = 0;
  logic [7:0] q[$];
  logic [7:0] lastSent = 8'hFF;
  bit mUf = 0, mOf = 0;

  always #4 clk = ~clk;

  uart_pcm_slip_bridge #(.DEPTH(DEPTH), .HIGH_MARK(HIGH), .LOW_MARK(LOW), .OVS_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial), .pcmBitClk(pcmBitClk),
    .slotEnable(slotEnable), .pcmData(pcmData),
    .underflowFlag(underflowFlag), .overflowFlag(overflowFlag)
  );

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxSerial = 1'b1; pcmBitClk = 1'b0; slotEnable = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    q.delete(); lastSent = 8'hFF; mUf = 0; mOf = 0;
    repeat (2) @(negedge clk);
    // R5 R11: reset state
    chk("R5 idle after reset", pcmData, 1);
    chk("R11 uf clear", underflowFlag, 0);
    chk("R11 of clear", overflowFlag, 0);
  endtask

  task automatic checkFlags(string where);
    chk({"R9 uf ", where}, underflowFlag, mUf);
    chk({"R10 of ", where}, overflowFlag, mOf);
  endtask

  // R1 R3: one serial frame, LSB first; stopOk=0 drives a low stop bit
  task automatic sendByte(logic [7:0] b, bit stopOk);
    @(negedge clk);
    rxSerial = 1'b0; repeat (BIT_LEN) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxSerial = b[k]; repeat (BIT_LEN) @(negedge clk);
    end
    rxSerial = stopOk; repeat (BIT_LEN) @(negedge clk);
    rxSerial = 1'b1; repeat (2 * BIT_LEN) @(negedge clk);
    if (stopOk) begin
      if (q.size() == DEPTH) mOf = 1;
      else q.push_back(b);
    end
    checkFlags("after byte");
  endtask

  // R2: short low glitch
  task automatic glitch();
    @(negedge clk);
    rxSerial = 1'b0; repeat (3 * DIV) @(negedge clk);
    rxSerial = 1'b1; repeat (2 * BIT_LEN) @(negedge clk);
  endtask

  // One frame: 12 bit clocks, slot on clocks 2..9, 8 system clocks per bit
  task automatic runFrame();
    logic [7:0] b = 8'hFF;
    string tag = "R4";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      pcmBitClk = 1'b1;
      if (i == 2) begin
        if (q.size() == 0) begin b = lastSent; mUf = 1; tag = "R9"; end
        else if (q.size() > HIGH) begin void'(q.pop_front()); b = q.pop_front(); tag = "R7"; end
        else if (q.size() < LOW) begin b = lastSent; tag = "R8"; end
        else begin b = q.pop_front(); tag = "R6"; end
        lastSent = b;
      end
      repeat (4) @(negedge clk);
      pcmBitClk = 1'b0;
      slotEnable = (i + 1 >= 2) && (i + 1 <= 9);
      repeat (2) @(negedge clk);
      if (i >= 2 && i <= 9) chk({tag, " R4 slot bit"}, pcmData, b[9 - i]);
      else chk("R5 idle bit", pcmData, 1);
      @(negedge clk);
    end
    checkFlags("after frame");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R9: empty FIFO repeats 0xFF and sets underflow
    repeat (2) runFrame();
    // R11: flag survives more frames, cleared by reset
    runFrame();
    doReset();

    // R1 R6 R8: moderate fill, pops then repeats below the low mark
    for (int i = 0; i < 12; i++) sendByte(8'h30 + 8'(i * 7), 1'b1);
    repeat (8) runFrame();

    // R7: push above the high mark, expect drops
    for (int i = 0; i < 20; i++) sendByte(8'hA0 ^ 8'(i * 13), 1'b1);
    repeat (6) runFrame();

    // R10: fill past capacity
    for (int i = 0; i < 14; i++) sendByte(8'h55 + 8'(i * 29), 1'b1);
    repeat (20) runFrame();

    // R2 R3: glitch and bad stop bit must add nothing
    doReset();
    glitch();
    sendByte(8'hC3, 1'b0);
    glitch();
    for (int i = 0; i < 10; i++) sendByte(8'h11 * 8'(i + 1), 1'b1);
    repeat (5) runFrame();

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule